// File: doc/BRIEF.md
# Wired-aware random replacement index generator

This block picks the slot that a write-random translation-table operation overwrites. It keeps a pseudo-random generator, the count of active entries, and a lower boundary register. Entries below the boundary are reserved, and the block never names one of them. On each request strobe the generator steps once. The block then reduces the new state into the range that runs from the boundary up to the active count minus one, and presents the result one cycle later with a valid pulse.

The active entry count can be reloaded at run time. A reload also resets the boundary and the presented index. Software can write the boundary at any time. The stored boundary is the written value reduced modulo the active count, so the range of replaceable entries never becomes empty.

Top module: `rnd_repl_idx`

## Requirements
- R1: After reset the presented index is RESET_COUNT-1 (15 with defaults), the boundary is 0, the valid flag is 0, the active count is RESET_COUNT, and the generator state is 0.
- R2: Each accepted request replaces the 32-bit generator state s by (s*314159+1) mod 2^32. When no request is accepted the state does not move, so the sequence of indices depends only on the number of accepted requests.
- R3: A request accepted in cycle n gives index = ((s_new >> 16) mod (count - boundary)) + boundary in cycle n+1, with idx_valid high for exactly that cycle. The boundary used is the one held before the cycle of the request.
- R4: Every presented index with idx_valid high lies in [boundary, count-1].
- R5: A boundary write stores wired_wdata mod count. The new value appears on wired_idx the next cycle.
- R6: A configuration load sets count = cfg_count_m1 + 1, the index to count-1 and the boundary to 0. It overrides a boundary write in the same cycle. A request in the same cycle is ignored: the state does not advance and no valid pulse follows.
- R7: When the boundary equals count-1, every presented index is count-1.
- R8: When a boundary write and a request share a cycle, the index is reduced with the old boundary, and the new boundary shows the next cycle.
- R9: Between requests and configuration loads, the presented index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load a new active entry count |
| cfg_count_m1 | input | IDX_W | New active count minus one |
| wired_we | input | 1 | Boundary write strobe |
| wired_wdata | input | 32 | Raw boundary value from software |
| req | input | 1 | Index request strobe |
| rand_idx | output | IDX_W | Presented replacement index |
| idx_valid | output | 1 | High one cycle after an accepted request |
| wired_idx | output | IDX_W | Current boundary |

## Verification
Some properties are checked by assertions on every cycle. An index with valid high must stay inside the count and at or above the previous boundary. The boundary must stay below the count. The generator state and the presented index must hold when nothing acts on them. A request must be followed by exactly one valid pulse. A configuration load must leave the index at count-1 and the boundary at zero. Other behaviour can only be shown by the bench scenarios, which compare against an independently computed sequence over thousands of requests at several counts and boundaries. These scenarios cover the exact generator sequence, the modulo reduction of the index and of boundary writes, reset values, a request dropped in a configuration cycle, and the old-boundary rule for a write in the same cycle.

// File: rtl/rnd_repl_pkg.sv
package rnd_repl_pkg;

  localparam logic [31:0] LCG_MULT = 32'd314159;
  localparam logic [31:0] LCG_INC  = 32'd1;

  // One step of the congruential generator, wrapping at 32 bits.
  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MULT + LCG_INC;
  endfunction

  // Unsigned remainder by shift-and-subtract, one quotient bit per step.
  function automatic logic [31:0] urem32(input logic [31:0] num,
                                         input logic [31:0] den);
    logic [32:0] acc;
    acc = '0;
    for (int b = 31; b >= 0; b--) begin
      acc = {acc[31:0], num[b]};
      if (acc >= {1'b0, den}) acc = acc - {1'b0, den};
    end
    return acc[31:0];
  endfunction

endpackage

// File: rtl/rig_seed_gen.sv
module rig_seed_gen
  import rnd_repl_pkg::*;
#(
  parameter int SEED_W   = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [SEED_W-1:0]   seed_q,
  output logic [SAMPLE_W-1:0] sample_nxt
);
  localparam int SAMPLE_LSB = SEED_W - SAMPLE_W;

  logic [SEED_W-1:0] seed_nxt;

  always_comb seed_nxt = lcg_next(seed_q);
  assign sample_nxt = seed_nxt[SEED_W-1:SAMPLE_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n)       seed_q <= '0;
    else if (advance) seed_q <= seed_nxt;
  end
endmodule

// File: rtl/rig_range_reduce.sv
module rig_range_reduce
  import rnd_repl_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int CNT_W    = 7,
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [IDX_W-1:0]    floor_idx,
  input  logic [CNT_W-1:0]    count,
  output logic [IDX_W-1:0]    idx
);
  logic [CNT_W-1:0] span;
  logic [31:0]      rem;

  always_comb begin
    span = count - CNT_W'(floor_idx);
    rem  = urem32(32'(sample), 32'(span));
    idx  = IDX_W'(rem) + floor_idx;
  end
endmodule

// File: rtl/rig_wired_reg.sv
module rig_wired_reg
  import rnd_repl_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             write,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] wired_q
);
  logic [31:0] reduced;

  always_comb reduced = urem32(wdata, 32'(count));

  always_ff @(posedge clk) begin
    if (!rst_n)     wired_q <= '0;
    else if (clear) wired_q <= '0;
    else if (write) wired_q <= IDX_W'(reduced);
  end
endmodule

// File: rtl/rnd_repl_idx.sv
module rnd_repl_idx #(
  parameter int MAX_ENTRIES = 64,
  parameter int RESET_COUNT = 16,
  parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [IDX_W-1:0] cfg_count_m1,
  input  logic             wired_we,
  input  logic [31:0]      wired_wdata,
  input  logic             req,
  output logic [IDX_W-1:0] rand_idx,
  output logic             idx_valid,
  output logic [IDX_W-1:0] wired_idx
);
  localparam int CNT_W    = IDX_W + 1;
  localparam int SEED_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // Named events, brought out for the checker.
  logic accept_req;
  logic accept_wr;
  assign accept_req = req && !cfg_load;
  assign accept_wr  = wired_we && !cfg_load;

  logic [CNT_W-1:0]    count_q;
  logic [CNT_W-1:0]    cfg_count;
  logic [SEED_W-1:0]   seed_q;
  logic [SAMPLE_W-1:0] sample_nxt;
  logic [IDX_W-1:0]    wired_q;
  logic [IDX_W-1:0]    reduced_idx;

  assign cfg_count = CNT_W'(cfg_count_m1) + CNT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= CNT_W'(RESET_COUNT);
    else if (cfg_load) count_q <= cfg_count;
  end

  rig_seed_gen #(.SEED_W(SEED_W), .SAMPLE_W(SAMPLE_W)) seed_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (accept_req),
    .seed_q    (seed_q),
    .sample_nxt(sample_nxt)
  );

  rig_wired_reg #(.IDX_W(IDX_W), .CNT_W(CNT_W)) wired_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cfg_load),
    .write  (accept_wr),
    .wdata  (wired_wdata),
    .count  (count_q),
    .wired_q(wired_q)
  );

  rig_range_reduce #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W)) reduce_i (
    .sample   (sample_nxt),
    .floor_idx(wired_q),
    .count    (count_q),
    .idx      (reduced_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rand_idx  <= IDX_W'(RESET_COUNT - 1);
      idx_valid <= 1'b0;
    end else begin
      idx_valid <= accept_req;
      if (cfg_load)        rand_idx <= IDX_W'(cfg_count - CNT_ONE);
      else if (accept_req) rand_idx <= reduced_idx;
    end
  end

  assign wired_idx = wired_q;
endmodule

// File: rtl/rnd_repl_idx_chk.sv
module rnd_repl_idx_chk #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             accept_req,
  input logic [CNT_W-1:0] count_q,
  input logic [IDX_W-1:0] wired_q,
  input logic [31:0]      seed_q,
  input logic [IDX_W-1:0] rand_idx,
  input logic             idx_valid
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> ({1'b0, rand_idx} < count_q) && (rand_idx >= $past(wired_q)));

  assert_wired_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, wired_q} < count_q);

  assert_cfg_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> ({1'b0, rand_idx} == count_q - ONE) && (wired_q == '0) && !idx_valid);

  assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_req |=> idx_valid);

  assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_req |=> !idx_valid);

  assert_seed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_req |=> $stable(seed_q));

  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_req && !cfg_load) |=> $stable(rand_idx));

  assert_full_wired_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_req && ({1'b0, wired_q} == count_q - ONE)) |=> ({1'b0, rand_idx} == count_q - ONE));
endmodule

bind rnd_repl_idx rnd_repl_idx_chk #(.IDX_W(IDX_W), .CNT_W(IDX_W + 1)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .accept_req(accept_req),
  .count_q   (count_q),
  .wired_q   (wired_q),
  .seed_q    (seed_q),
  .rand_idx  (rand_idx),
  .idx_valid (idx_valid)
);

// File: tb/rnd_repl_idx_tb_top.sv
module rnd_repl_idx_tb_top;
  localparam int IDX_W = 6;
  localparam int NVEC  = 8;

  // Per row: count minus one, raw boundary write, expected boundary, request count.
  localparam int unsigned V_CM1[NVEC]  = '{15, 47,  63, 0,   2, 31, 63,    7};
  localparam int unsigned V_WR[NVEC]   = '{ 0,  5, 100, 7,   2, 32, 63, 1003};
  localparam int unsigned V_WEXP[NVEC] = '{ 0,  5,  36, 0,   2,  0, 63,    3};
  localparam int unsigned V_NREQ[NVEC] = '{600, 600, 500, 50, 100, 400, 100, 400};

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_load = 0;
  logic [IDX_W-1:0] cfg_count_m1 = '0;
  logic wired_we = 0;
  logic [31:0] wired_wdata = '0;
  logic req = 0;
  logic [IDX_W-1:0] rand_idx;
  logic idx_valid;
  logic [IDX_W-1:0] wired_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int unsigned m_seed  = 0;
  int unsigned m_count = 16;
  int unsigned m_wired = 0;

  always #2ns clk = ~clk;

  rnd_repl_idx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count_m1(cfg_count_m1),
    .wired_we(wired_we), .wired_wdata(wired_wdata), .req(req),
    .rand_idx(rand_idx), .idx_valid(idx_valid), .wired_idx(wired_idx)
  );

  task automatic check(string tag, int unsigned got, int unsigned exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int unsigned model_idx();
    m_seed = m_seed * 32'd314159 + 32'd1;
    return ((m_seed >> 16) % (m_count - m_wired)) + m_wired;
  endfunction

  task automatic do_cfg(int unsigned cm1);
    @(negedge clk); cfg_load = 1; cfg_count_m1 = IDX_W'(cm1);
    @(negedge clk); cfg_load = 0;
    m_count = cm1 + 1; m_wired = 0;
    check("R6 index after load", rand_idx, m_count - 1);
    check("R6 boundary after load", wired_idx, 0);
  endtask

  task automatic do_wired(int unsigned v);
    @(negedge clk); wired_we = 1; wired_wdata = v;
    @(negedge clk); wired_we = 0;
    m_wired = v % m_count;
  endtask

  task automatic burst(int unsigned n, string tag);
    @(negedge clk); req = 1;
    for (int i = 0; i < int'(n); i++) begin
      int unsigned e;
      @(negedge clk);
      if (i == int'(n) - 1) req = 0;
      e = model_idx();
      check(tag, rand_idx, e);
      check("R3 valid pulse", idx_valid, 1);
      n_tests++;
      if (rand_idx < m_wired || rand_idx > m_count - 1) begin
        n_fail++;
        $display("FAIL R4 range: got %0d expected [%0d,%0d]", rand_idx, m_wired, m_count - 1);
      end
    end
  endtask

  initial begin
    #400us;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int unsigned hold;
    int unsigned e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 index", rand_idx, 15);
    check("R1 boundary", wired_idx, 0);
    check("R1 valid", idx_valid, 0);
    burst(40, "R2 sequence from reset");

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      do_cfg(V_CM1[v]);
      do_wired(V_WR[v]);
      check("R5 boundary mod count", wired_idx, V_WEXP[v]);
      burst(V_NREQ[v], (V_WEXP[v] == V_CM1[v]) ? "R7 full boundary" : "R3 table index");
    end

    // R9 hold and single valid pulse
    hold = rand_idx;
    repeat (5) @(negedge clk);
    check("R9 index holds", rand_idx, hold);
    check("R3 valid drops", idx_valid, 0);

    // R6 request in load cycle is dropped
    @(negedge clk); cfg_load = 1; cfg_count_m1 = 6'd19; req = 1; wired_we = 1; wired_wdata = 9;
    @(negedge clk); cfg_load = 0; req = 0; wired_we = 0;
    m_count = 20; m_wired = 0;
    check("R6 no valid on load", idx_valid, 0);
    check("R6 index count-1", rand_idx, 19);
    check("R6 load beats write", wired_idx, 0);
    burst(20, "R2 seed did not move on load");

    // R8 write and request together
    do_wired(4);
    @(negedge clk); wired_we = 1; wired_wdata = 17; req = 1;
    @(negedge clk); wired_we = 0; req = 0;
    e = model_idx();
    check("R8 old boundary used", rand_idx, e);
    m_wired = 17;
    check("R8 new boundary visible", wired_idx, 17);
    burst(200, "R8 index with new boundary");

    // R7 boundary at count-1 via write
    do_wired(19 + 20 * 5);
    check("R5 large write reduced", wired_idx, 19);
    burst(30, "R7 boundary at top");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule